// File: doc/BRIEF.md
# On-Chip Data RAM Access Router

This block sits between an 8051-style core's external-data port and the rest of the chip. It steers each external-data read or write either to an on-chip data RAM or to the external bus. That on-chip RAM is mapped at the top of the 64 KB external data space, from F700h to FFFFh. A 16-bit access uses the address as given. An 8-bit indirect access takes its upper byte from a page register and its lower byte from the register operand.

A control register holds two bits:
- **Disable bit (bit 0).** While it is set, the on-chip RAM is unreachable. Software can clear it but cannot set it again; only reset sets it.
- **Mirror bit (bit 1).** It selects whether cycles that go to the on-chip RAM also drive the external strobes and ports, so the address and data appear outside the chip.

The chip-select and the routing are a single-cycle combinational decode of the access request. The two registers are written through a simple special-function-register port.

Top module: `xac_top`

## Requirements
- R1: With the RAM enabled (control bit 0 = 0) and 16-bit mode (`acc_wide` = 1), `ram_cs` is 1 for a read or write request exactly when the address lies from F700h to FFFFh inclusive.
- R2: In 8-bit mode (`acc_wide` = 0), the effective address is {page register, `acc_addr[7:0]`}. It appears on `ext_addr` and is used for the range decode.
- R3: After reset, control bit 0 is 1. While it is 1, `ram_cs` stays 0 and every request goes to the external bus.
- R4: A control write with bit 0 = 0 clears the disable bit. Later writes with bit 0 = 1 leave it cleared, and only reset sets it again.
- R5: With the mirror bit (control bit 1) at 0, an access that hits the enabled RAM leaves `ext_rd`, `ext_wr` and `ext_drive` at 0.
- R6: With the mirror bit at 1, an access that hits the enabled RAM also asserts `ext_drive` and the matching `ext_rd` or `ext_wr`.
- R7: When the address is outside the RAM range or the RAM is disabled, `ext_drive`, `ext_rd` and `ext_wr` follow the request, whatever the mirror bit holds.
- R8: The control register lives at SFR address B1h and reads as {101000b, mirror, disable}, so it reads A1h after reset.
- R9: The page register lives at SFR address 91h and resets to 00h. It reads back the last value written, and the new value is used from the next access onward. Other SFR addresses read 00h.
- R10: On a RAM hit, `ram_rd` or `ram_wr` follows the request, and `ram_ofs` equals the effective address minus F700h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR address for register read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| acc_addr | input | 16 | Access address (only the low byte is used in 8-bit mode) |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_wide | input | 1 | 1 = 16-bit addressing, 0 = 8-bit paged addressing |
| ram_cs | output | 1 | On-chip RAM chip-select |
| ram_rd | output | 1 | On-chip RAM read enable |
| ram_wr | output | 1 | On-chip RAM write enable |
| ram_ofs | output | 12 | Offset into the on-chip RAM |
| ext_addr | output | 16 | Effective address presented to the external ports |
| ext_drive | output | 1 | External ports 0 and 2 driven this cycle |
| ext_rd | output | 1 | External read strobe (active high) |
| ext_wr | output | 1 | External write strobe (active high) |

## Verification
The assertions assume the core never raises a read and a write request in the same cycle. The routing properties are only meaningful under that assumption, and the random stimulus picks exactly one of read, write or idle for every access. They also assume that SFR writes and accesses are sampled on the same clock. The bench therefore applies all inputs on the falling edge, so a register write lands on the next rising edge before the following access is checked.

// File: rtl/xac_pkg.sv
package xac_pkg;
  // Fixed upper bits of the control register as read back
  localparam logic [5:0] CTRL_FIXED = 6'b101000;

  typedef struct packed {
    logic mirror;   // bit 1
    logic disable_; // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{mirror: 1'b0, disable_: 1'b1};
endpackage

// File: rtl/xac_sfr.sv
module xac_sfr
  import xac_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'hB1,
  parameter logic [7:0]  PAGE_ADDR = 8'h91
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] page
);
  logic ctrl_hit, page_hit;
  assign ctrl_hit = (sfr_addr == CTRL_ADDR);
  assign page_hit = (sfr_addr == PAGE_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RESET;
      page <= '0;
    end else begin
      if (sfr_we && ctrl_hit) begin
        ctrl.mirror   <= sfr_wdata[1];
        // disable bit can only be cleared by software
        ctrl.disable_ <= ctrl.disable_ & sfr_wdata[0];
      end
      if (sfr_we && page_hit)
        page <= sfr_wdata;
    end
  end

  always_comb begin
    sfr_rdata = '0;
    if (ctrl_hit)
      sfr_rdata[7:0] = {CTRL_FIXED, ctrl.mirror, ctrl.disable_};
    else if (page_hit)
      sfr_rdata = page;
  end

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.disable_ |=> !ctrl.disable_); // R4
  AST_PAGE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !(sfr_we && page_hit) |=> $stable(page)); // R9
endmodule

// File: rtl/xac_decode.sv
module xac_decode
  import xac_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] RAM_BASE  = 16'hF700,
  localparam int               RAM_SIZE  = (1 << ADDR_W) - int'(RAM_BASE),
  localparam int               OFS_W     = $clog2(RAM_SIZE),
  localparam int               LOW_W     = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] page,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_wide,
  output logic              ram_cs,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [OFS_W-1:0]  ram_ofs,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_drive,
  output logic              ext_rd,
  output logic              ext_wr
);
  logic [ADDR_W-1:0] eff;
  logic [ADDR_W-1:0] diff;
  logic              in_range, req, to_ext;

  assign eff      = acc_wide ? acc_addr : {page, acc_addr[LOW_W-1:0]};
  assign in_range = (eff >= RAM_BASE);
  assign req      = acc_rd | acc_wr;
  assign diff     = eff - RAM_BASE;

  assign ram_cs   = req & in_range & ~ctrl.disable_;
  assign ram_rd   = ram_cs & acc_rd;
  assign ram_wr   = ram_cs & acc_wr;
  assign ram_ofs  = diff[OFS_W-1:0];

  assign to_ext    = req & (~ram_cs | ctrl.mirror);
  assign ext_addr  = eff;
  assign ext_drive = to_ext;
  assign ext_rd    = to_ext & acc_rd;
  assign ext_wr    = to_ext & acc_wr;

  AST_CS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ram_cs |-> (ext_addr >= RAM_BASE)); // R1
  AST_DISABLED_NO_CS: assert property (@(posedge clk) disable iff (rst)
    ctrl.disable_ |-> !ram_cs); // R3
  AST_HIDDEN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ram_cs && !ctrl.mirror) |-> (!ext_rd && !ext_wr && !ext_drive)); // R5
  AST_MIRRORED_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ram_cs && ctrl.mirror) |-> (ext_drive && (ext_rd == ram_rd) && (ext_wr == ram_wr))); // R6
  AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !ram_cs |-> (ext_rd == acc_rd && ext_wr == acc_wr)); // R7
  AST_RAM_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_rd, acc_wr}) |-> $onehot0({ram_rd, ram_wr})); // R10
endmodule

// File: rtl/xac_top.sv
module xac_top
  import xac_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] RAM_BASE  = 16'hF700,
  parameter logic [7:0]  CTRL_ADDR = 8'hB1,
  parameter logic [7:0]  PAGE_ADDR = 8'h91,
  localparam int         OFS_W     = $clog2((1 << ADDR_W) - int'(RAM_BASE))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic              sfr_we,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic              acc_wide,
  output logic              ram_cs,
  output logic              ram_rd,
  output logic              ram_wr,
  output logic [OFS_W-1:0]  ram_ofs,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_drive,
  output logic              ext_rd,
  output logic              ext_wr
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] page;

  xac_sfr #(
    .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .PAGE_ADDR(PAGE_ADDR)
  ) u_sfr (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ctrl(ctrl), .page(page)
  );

  xac_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_BASE(RAM_BASE[ADDR_W-1:0])
  ) u_dec (
    .clk(clk), .rst(rst), .ctrl(ctrl), .page(page),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wide(acc_wide),
    .ram_cs(ram_cs), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_ofs(ram_ofs),
    .ext_addr(ext_addr), .ext_drive(ext_drive), .ext_rd(ext_rd), .ext_wr(ext_wr)
  );
endmodule

// File: tb/tb_xac_top.sv
module tb_xac_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
  logic        sfr_we;
  logic [15:0] acc_addr, ext_addr;
  logic        acc_rd, acc_wr, acc_wide;
  logic        ram_cs, ram_rd, ram_wr, ext_drive, ext_rd, ext_wr;
  logic [11:0] ram_ofs;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // model state
  bit       m_dis, m_mir;
  bit [7:0] m_page;

  always #2 clk = ~clk; // 250 MHz

  xac_top dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .acc_addr(acc_addr),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wide(acc_wide),
    .ram_cs(ram_cs), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_ofs(ram_ofs),
    .ext_addr(ext_addr), .ext_drive(ext_drive), .ext_rd(ext_rd), .ext_wr(ext_wr)
  );

  function automatic bit [15:0] f_eff(bit [15:0] a, bit wide);
    return wide ? a : {m_page, a[7:0]};
  endfunction

  function automatic bit f_hit(bit [15:0] a, bit wide, bit rd, bit wr);
    return (rd | wr) && (f_eff(a, wide) >= 16'hF700) && !m_dis;
  endfunction

  function automatic bit [7:0] f_sfr(bit [7:0] a);
    if (a == 8'hB1) return {6'b101000, m_mir, m_dis};
    if (a == 8'h91) return m_page;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; sfr_we = 0; acc_rd = 0; acc_wr = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_dis = 1; m_mir = 0; m_page = 8'h00;
  endtask

  task automatic sfr_write(bit [7:0] a, bit [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1;
    @(negedge clk);
    sfr_we = 0;
    if (a == 8'hB1) begin m_mir = d[1]; m_dis = m_dis & d[0]; end
    if (a == 8'h91) m_page = d;
  endtask

  task automatic sfr_read(bit [7:0] a, string req);
    @(negedge clk);
    sfr_addr = a; #1;
    chk(req, 32'(sfr_rdata), 32'(f_sfr(a)));
  endtask

  task automatic access(bit [15:0] a, bit rd, bit wr, bit wide);
    bit hit, to_ext;
    bit [15:0] e;
    @(negedge clk);
    acc_addr = a; acc_rd = rd; acc_wr = wr; acc_wide = wide; #1;
    e = f_eff(a, wide);
    hit = f_hit(a, wide, rd, wr);
    to_ext = (rd | wr) && (!hit || m_mir);
    chk(wide ? "R1 cs" : "R2 cs paged", 32'(ram_cs), 32'(hit));
    chk("R2 ext_addr", 32'(ext_addr), 32'(e));
    chk(hit ? (m_mir ? "R6 drive" : "R5 drive") : "R7 drive", 32'(ext_drive), 32'(to_ext));
    chk(hit ? (m_mir ? "R6 rd/wr" : "R5 rd/wr") : "R7 rd/wr",
        32'({ext_rd, ext_wr}), 32'({to_ext & rd, to_ext & wr}));
    chk("R10 ram strobes", 32'({ram_rd, ram_wr}), 32'({hit & rd, hit & wr}));
    if (hit) chk("R10 ofs", 32'(ram_ofs), 32'(e - 16'hF700));
    @(negedge clk);
    acc_rd = 0; acc_wr = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; sfr_addr = 0; sfr_wdata = 0; sfr_we = 0;
    acc_addr = 0; acc_rd = 0; acc_wr = 0; acc_wide = 1;
    do_reset();

    // R8 reset read, R9 page reset
    sfr_read(8'hB1, "R8 reset ctrl");
    chk("R8 reset value", 32'(sfr_rdata), 32'h0A1);
    sfr_read(8'h91, "R9 page reset");
    sfr_read(8'h55, "R9 other addr");
    // R3: disabled after reset, in-range goes external
    access(16'hF700, 1, 0, 1);
    chk("R3 no cs after reset", 32'(ram_cs), 32'(0));
    access(16'hFFFF, 0, 1, 1);
    // R4 enable then try to re-disable
    sfr_write(8'hB1, 8'h00);
    sfr_read(8'hB1, "R4 cleared");
    access(16'hF6FF, 1, 0, 1);  // just below R1
    access(16'hF700, 1, 0, 1);  // lower edge R1
    access(16'hFFFF, 0, 1, 1);  // top edge R1
    sfr_write(8'hB1, 8'h01);
    sfr_read(8'hB1, "R4 lock held");
    access(16'hF800, 1, 0, 1);
    // R6 mirror on
    sfr_write(8'hB1, 8'h02);
    access(16'hFA00, 1, 0, 1);
    access(16'hFA01, 0, 1, 1);
    access(16'h1234, 1, 0, 1);  // R7 outside range with mirror
    // R2/R9 paged
    sfr_write(8'h91, 8'hF7);
    sfr_read(8'h91, "R9 page readback");
    access(16'h0010, 1, 0, 0);
    sfr_write(8'h91, 8'hF6);
    access(16'hFFFF, 0, 1, 0);  // F6FF: outside
    sfr_write(8'hB1, 8'h00);
    sfr_write(8'h91, 8'hFF);
    access(16'h00FF, 0, 1, 0);
    // reset restores R4
    do_reset();
    sfr_read(8'hB1, "R4 reset sets disable");
    access(16'hF900, 1, 0, 1);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) sfr_write(8'hB1, 8'($urandom()) | (($urandom_range(0, 3) != 0) ? 8'h01 : 8'h00));
      else if (op == 1) sfr_write(8'h91, ($urandom_range(0, 1) != 0) ? 8'($urandom_range(8'hF0, 8'hFF)) : 8'($urandom()));
      else if (op == 2) sfr_read(($urandom_range(0, 1) != 0) ? 8'hB1 : 8'h91, "R8 R9 random read");
      else if (op == 3 && $urandom_range(0, 7) == 0) do_reset();
      else begin
        int k;
        bit [15:0] a;
        k = int'($urandom_range(0, 2));
        a = ($urandom_range(0, 1) != 0) ? 16'($urandom_range(16'hF600, 16'hFFFF)) : 16'($urandom());
        access(a, k == 0, k == 1, $urandom_range(0, 1) != 0);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule